// File: doc/BRIEF.md
# Transfer latch and digit readout multiplexer

This block sits behind a five-digit decimal event counter. It freezes the counter state into holding storage on command, then shows the stored digits one at a time on a shared 4-bit BCD bus. The counter state has four decades of four bits each and a one-bit overload digit. A transfer input decides whether the readout follows the live counter or keeps the last captured value. The counting logic lives elsewhere.

Three select lines pick the digit. The top line picks the overload digit and overrides the other two. With the top line low, the other two lines pick one of the four decades in binary order. An enable input either drives the bus or releases it to high impedance, so several readouts can share one wire bundle. The bus is offered two ways: as a data word with a per-bit drive enable, and as a resolved tri-state port.

Holding storage is a clocked register. While transfer is high it reloads on every edge, and a combinational bypass makes the live value visible in the same cycle. The result behaves like a transparent latch inside a synchronous design.

Top module: `digit_latch_readout`

## Requirements
- R1: While rst_ni is low, the held digits are cleared to zero. With transfer low, every selection then reads 0000.
- R2: While xfer_i is high, the outputs show the live counter inputs in the same cycle, with no clock edge needed. The held copy takes the live value at every rising clock edge.
- R3: While xfer_i is low, the held digits keep the last value captured. Changes on cnt_dec_i and cnt_top_i have no effect on the outputs.
- R4: With sel_i[2] low, the value v = sel_i[0] + 2*sel_i[1] selects decade v+1, with decade 1 the least significant. Decade k occupies cnt_dec_i[4k-1:4k-4].
- R5: With sel_i[2] high, the overload digit is selected, whatever the values of sel_i[1:0].
- R6: When the overload digit is selected, its value drives the lowest two output bits as a zero-extended field (bit 0 carries the digit, bit 1 is 0). Bits 3 and 2 are driven low.
- R7: With oe_i high, all four bits of bcd_drv_o are 1 and bcd_bus_o equals bcd_data_o. With oe_i low, all four bits of bcd_drv_o are 0 and every bit of bcd_bus_o is z.
- R8: bcd_data_o always carries the selected digit as positive-logic BCD, whatever the level of oe_i.
- R9: sel_i and oe_i act combinationally. A change on either reaches the outputs before the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the held digits |
| cnt_dec_i | input | 16 | Live counter decades, decade 1 in bits 3:0 |
| cnt_top_i | input | 1 | Live overload digit |
| xfer_i | input | 1 | Transfer: high passes live state, low holds |
| sel_i | input | 3 | Digit select; bit 2 picks the overload digit |
| oe_i | input | 1 | Output enable for the BCD bus |
| bcd_data_o | output | 4 | Selected digit, always driven |
| bcd_drv_o | output | 4 | Per-bit drive enable |
| bcd_bus_o | output | 4 | Resolved tri-state BCD bus |

## Verification
On every cycle, the assertions check three things. The held copy stays frozen while transfer is low and tracks the live input while it is high. An overload selection never drives the upper bits. The drive enables are always all-on or all-off and agree with the bus. The decade ordering of the select code, the same-cycle transparency, and the high-impedance bus values appear only through the bench's scenarios. In those scenarios, a behavioural model predicts each digit from the inputs and from the transfer history.

// File: rtl/dlr_pkg.sv
package dlr_pkg;
  localparam int BCD_W = 4;
  typedef logic [BCD_W-1:0] bcd_t;
endpackage

// File: rtl/dlr_hold.sv
module dlr_hold #(
  parameter int NUM_DEC = 4,
  parameter int DIGIT_W = 4,
  parameter int TOP_W   = 1,
  localparam int DEC_BITS = NUM_DEC * DIGIT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                xfer_i,
  input  logic [DEC_BITS-1:0] live_dec_i,
  input  logic [TOP_W-1:0]    live_top_i,
  output logic [DEC_BITS-1:0] view_dec_o,
  output logic [TOP_W-1:0]    view_top_o
);
  logic [DEC_BITS-1:0] held_dec_q;
  logic [TOP_W-1:0]    held_top_q;

  for (genvar d = 0; d < NUM_DEC; d++) begin : g_dec
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     held_dec_q[d*DIGIT_W +: DIGIT_W] <= '0;
      else if (xfer_i) held_dec_q[d*DIGIT_W +: DIGIT_W] <= live_dec_i[d*DIGIT_W +: DIGIT_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     held_top_q <= '0;
    else if (xfer_i) held_top_q <= live_top_i;
  end

  // bypass gives same-cycle transparency while transfer is high
  assign view_dec_o = xfer_i ? live_dec_i : held_dec_q;
  assign view_top_o = xfer_i ? live_top_i : held_top_q;

  assert_hold_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_i |=> ($stable(held_dec_q) && $stable(held_top_q)));

  assert_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i |=> (held_dec_q == $past(live_dec_i) && held_top_q == $past(live_top_i)));
endmodule

// File: rtl/dlr_select.sv
module dlr_select #(
  parameter int NUM_DEC     = 4,
  parameter int DIGIT_W     = 4,
  parameter int TOP_W       = 1,
  parameter int TOP_FIELD_W = 2,
  localparam int DEC_BITS = NUM_DEC * DIGIT_W,
  localparam int IDX_W    = $clog2(NUM_DEC),
  localparam int SEL_W    = IDX_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DEC_BITS-1:0] view_dec_i,
  input  logic [TOP_W-1:0]    view_top_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic [DIGIT_W-1:0]  digit_o
);
  logic [IDX_W-1:0] idx;
  logic             pick_top;

  assign pick_top = sel_i[SEL_W-1];
  assign idx      = sel_i[IDX_W-1:0];

  always_comb begin
    digit_o = '0;
    if (pick_top) digit_o[TOP_W-1:0] = view_top_i;
    else          digit_o = view_dec_i[idx*DIGIT_W +: DIGIT_W];
  end

  assert_top_upper_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pick_top |-> (digit_o[DIGIT_W-1:TOP_FIELD_W] == '0 && digit_o[TOP_FIELD_W-1:TOP_W] == '0));
endmodule

// File: rtl/dlr_drive.sv
module dlr_drive #(
  parameter int W = 4
) (
  input  logic [W-1:0] data_i,
  input  logic         oe_i,
  output logic [W-1:0] data_o,
  output logic [W-1:0] drv_o,
  output tri   [W-1:0] bus_o
);
  assign data_o = data_i;
  assign drv_o  = {W{oe_i}};
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign bus_o[b] = drv_o[b] ? data_i[b] : 1'bz;
  end
endmodule

// File: rtl/digit_latch_readout.sv
module digit_latch_readout
  import dlr_pkg::*;
#(
  parameter int NUM_DEC = 4,
  parameter int TOP_W   = 1,
  localparam int DEC_BITS = NUM_DEC * BCD_W,
  localparam int SEL_W    = $clog2(NUM_DEC) + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DEC_BITS-1:0] cnt_dec_i,
  input  logic [TOP_W-1:0]    cnt_top_i,
  input  logic                xfer_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic                oe_i,
  output logic [BCD_W-1:0]    bcd_data_o,
  output logic [BCD_W-1:0]    bcd_drv_o,
  output tri   [BCD_W-1:0]    bcd_bus_o
);
  logic [DEC_BITS-1:0] view_dec;
  logic [TOP_W-1:0]    view_top;
  bcd_t                digit;

  dlr_hold #(.NUM_DEC(NUM_DEC), .DIGIT_W(BCD_W), .TOP_W(TOP_W)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .xfer_i(xfer_i),
    .live_dec_i(cnt_dec_i), .live_top_i(cnt_top_i),
    .view_dec_o(view_dec), .view_top_o(view_top)
  );

  dlr_select #(.NUM_DEC(NUM_DEC), .DIGIT_W(BCD_W), .TOP_W(TOP_W), .TOP_FIELD_W(2)) u_sel (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .view_dec_i(view_dec), .view_top_i(view_top),
    .sel_i(sel_i), .digit_o(digit)
  );

  dlr_drive #(.W(BCD_W)) u_drv (
    .data_i(digit), .oe_i(oe_i),
    .data_o(bcd_data_o), .drv_o(bcd_drv_o), .bus_o(bcd_bus_o)
  );

  assert_drive_all_or_none_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bcd_drv_o == '0) || (bcd_drv_o == '1));

  assert_bus_follows_data_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_i |-> (bcd_bus_o === bcd_data_o));

  assert_quiet_readout_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_i && !$past(xfer_i) && $stable(sel_i)) |-> $stable(bcd_data_o));
endmodule

// File: tb/digit_latch_readout_test.sv
`timescale 1ns/1ps
module digit_latch_readout_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt_dec = '0;
  logic [0:0]  cnt_top = '0;
  logic        xfer = 1'b0;
  logic [2:0]  sel = '0;
  logic        oe = 1'b0;
  logic [3:0]  data_o, drv_o;
  wire  [3:0]  bus_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int live_d[4];
  int live_t;
  int mdl_d[4];
  int mdl_t;

  always #5 clk = ~clk;

  digit_latch_readout uut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_dec_i(cnt_dec), .cnt_top_i(cnt_top),
    .xfer_i(xfer), .sel_i(sel), .oe_i(oe),
    .bcd_data_o(data_o), .bcd_drv_o(drv_o), .bcd_bus_o(bus_o)
  );

  // behavioural reference of the holding storage
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) mdl_d[i] = 0;
      mdl_t = 0;
    end else if (xfer) begin
      for (int i = 0; i < 4; i++) mdl_d[i] = live_d[i];
      mdl_t = live_t;
    end
  end

  task automatic check(string req, string what, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic expect_now(string req);
    int vd[4];
    int vt;
    logic [3:0] e_data, e_drv, e_bus;
    for (int i = 0; i < 4; i++) vd[i] = xfer ? live_d[i] : mdl_d[i];
    vt = xfer ? live_t : mdl_t;
    if (sel[2]) e_data = 4'(vt);
    else        e_data = 4'(vd[int'(sel[0]) + 2*int'(sel[1])]);
    e_drv = oe ? 4'hf : 4'h0;
    e_bus = oe ? e_data : 4'bzzzz;
    check(req, "data", data_o, e_data);
    check(req, "drive", drv_o, e_drv);
    check(req, "bus", bus_o, e_bus);
  endtask

  task automatic step(input int d0, input int d1, input int d2, input int d3, input int t,
                      input bit xf, input logic [2:0] s, input bit en, input string req);
    @(negedge clk);
    #1;
    live_d[0] = d0; live_d[1] = d1; live_d[2] = d2; live_d[3] = d3; live_t = t;
    cnt_dec = {4'(d3), 4'(d2), 4'(d1), 4'(d0)};
    cnt_top = 1'(t);
    xfer = xf; sel = s; oe = en;
    #2;
    expect_now(req);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    live_t = 0;
    for (int i = 0; i < 4; i++) live_d[i] = 0;
    // R1: reset state, transfer low
    step(7, 3, 9, 5, 1, 0, 3'b000, 1, "R1");
    step(7, 3, 9, 5, 1, 0, 3'b011, 1, "R1");
    step(7, 3, 9, 5, 1, 0, 3'b100, 1, "R1");
    @(negedge clk); rst_n = 1'b1;

    // R2: transparent, same cycle
    step(1, 2, 3, 4, 1, 1, 3'b000, 1, "R2");
    step(5, 6, 7, 8, 0, 1, 3'b000, 1, "R2");
    // R4: decade ordering while transparent
    step(1, 2, 3, 4, 1, 1, 3'b001, 1, "R4");
    step(1, 2, 3, 4, 1, 1, 3'b010, 1, "R4");
    step(1, 2, 3, 4, 1, 1, 3'b011, 1, "R4");
    // R5/R6: overload ignores low select lines
    for (int s = 4; s < 8; s++) step(9, 9, 9, 9, 1, 1, 3'(s), 1, "R5");
    step(9, 9, 9, 9, 0, 1, 3'b111, 1, "R6");
    step(9, 9, 9, 9, 1, 1, 3'b110, 1, "R6");
    // R3: hold last captured 9999/1 while inputs change
    step(0, 4, 2, 8, 0, 0, 3'b000, 1, "R3");
    step(6, 1, 5, 3, 0, 0, 3'b001, 1, "R3");
    step(6, 1, 5, 3, 0, 0, 3'b100, 1, "R3");
    // R9: select and enable change between edges while holding
    step(2, 2, 2, 2, 0, 0, 3'b010, 1, "R9");
    step(2, 2, 2, 2, 0, 0, 3'b011, 0, "R9");
    // R7/R8: released bus, data still present
    step(3, 1, 4, 1, 1, 0, 3'b000, 0, "R7");
    step(3, 1, 4, 1, 1, 0, 3'b100, 0, "R8");
    step(3, 1, 4, 1, 1, 1, 3'b010, 0, "R8");
    step(3, 1, 4, 1, 1, 0, 3'b010, 1, "R7");

    // mixed patterns compared on every clock
    for (int n = 0; n < 300; n++) begin
      step($urandom % 10, $urandom % 10, $urandom % 10, $urandom % 10, $urandom % 2,
           ($urandom % 3) == 0, 3'($urandom), ($urandom % 4) != 0, "R4");
    end

    // R1: asynchronous reset clears held copy
    @(negedge clk); rst_n = 1'b0;
    step(8, 8, 8, 8, 1, 0, 3'b011, 1, "R1");
    step(8, 8, 8, 8, 1, 0, 3'b100, 1, "R1");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule